// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block takes the six destination-address bytes at the head of an incoming Ethernet frame and decides whether the frame should be kept. Software controls the decision with three inputs: a receive-configuration byte, the station's own 48-bit address, and a 64-bit multicast hash mask. The block's verdict is an accept bit, a group flag that marks multicast or broadcast destinations, and a receive-status byte that a receive path can write in front of a stored frame.

A frame begins with a one-cycle `start` pulse. The address bytes then arrive on `byte_data` with `byte_valid`, first byte first, and may be separated by idle cycles. Group destinations are matched through a hash. A CRC-32 register is run over the 48 address bits, one bit per clock, and six bits of the result select one bit of the mask. The verdict therefore appears a fixed number of cycles after the sixth byte, and `done` marks it with a one-cycle strobe.

Within the 48-bit address and station vectors, the first address byte occupies bits 7:0 and the sixth occupies bits 47:40.

Top module: `rx_addr_filter`

## Requirements
- R1: When configuration bit 4 (value 0x10, promiscuous) is set, every frame is accepted regardless of its destination.
- R2: A destination whose six bytes are all 0xFF is broadcast. Without promiscuous mode it is accepted exactly when configuration bit 2 (0x04) is set, and the hash mask plays no part.
- R3: A non-broadcast destination whose first byte has bit 0 set is multicast. Without promiscuous mode it is accepted only when configuration bit 3 (0x08) is set and the mask bit selected by the hash index is 1.
- R4: The hash register is preset to 0xFFFFFFFF. The address bits are fed in from the first byte to the sixth, least significant bit of each byte first. For each bit, the feedback is register bit 31 XOR the data bit, and the register shifts left by one. When the feedback is 1, the register is XORed with 0x04C11DB6 and bit 0 is set to 1. The index is register bits 31:26, and mask bit `mcast_mask[index]` is used (index bits 5:3 pick the mask byte, bits 2:0 pick the bit within it).
- R5: A destination whose first byte has bit 0 clear is unicast. Without promiscuous mode it is accepted only when all six bytes equal `station_addr`.
- R6: With each verdict, `rx_status` is 0x01 for a unicast destination and 0x21 for a multicast or broadcast one, and `group_flag` is 1 exactly for multicast or broadcast destinations.
- R7: `done` is high for a single cycle, on the 50th rising edge after the edge that captures the sixth address byte. This holds whatever idle gaps separate the bytes.
- R8: Bytes presented after the sixth and before the next `start` have no effect on the verdict.
- R9: A `start` pulse abandons any evaluation in progress. No `done` follows for the abandoned frame.
- R10: After reset, `done`, `accept`, `group_flag` and `rx_status` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that opens a new frame |
| byte_valid | input | 1 | `byte_data` holds an address byte this cycle |
| byte_data | input | 8 | Destination-address byte, first byte first |
| rx_cfg | input | 8 | Receive configuration: bit 2 broadcast, bit 3 multicast, bit 4 promiscuous |
| station_addr | input | 48 | Own unicast address, first byte in bits 7:0 |
| mcast_mask | input | 64 | Multicast hash mask, indexed by the hash |
| done | output | 1 | One-cycle strobe: verdict valid |
| accept | output | 1 | Frame is accepted (held until the next verdict) |
| group_flag | output | 1 | Destination is multicast or broadcast |
| rx_status | output | 8 | Receive status byte for the verdict |

## Verification
Every configuration value from 0x00 to 0x1F is tried against four destination kinds: a matching unicast, a non-matching unicast, broadcast, and multicast. This shows that each enable bit gates only its own class and that promiscuous mode overrides all of them. Sixty-four multicast addresses are each run twice, once with only their bench-computed hash bit set in the mask and once with only that bit cleared. This pins the CRC arithmetic, the bit order and the index-to-mask mapping to the last bit.

For unicast, a mismatch in each of the six byte positions is used, so a comparator that skips a byte is caught. Further cases cover:
- gapped byte delivery and trailing extra bytes;
- a `start` pulse in the middle of an evaluation;
- the exact `done` latency.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // configuration bit positions
  localparam int CFG_BCAST_BIT   = 2;
  localparam int CFG_MCAST_BIT   = 3;
  localparam int CFG_PROMISC_BIT = 4;

  // status byte codes
  localparam logic [7:0] STAT_RX_OK = 8'h01;
  localparam logic [7:0] STAT_GROUP = 8'h20;

  typedef enum logic [1:0] {
    DST_UNICAST = 2'd0,
    DST_MULTI   = 2'd1,
    DST_BCAST   = 2'd2
  } dst_kind_e;

endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  output logic [8*ADDR_BYTES-1:0] addr_o,
  output logic                    complete_o
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] cnt_q;
  logic          take;

  assign take = byte_valid && !start && (cnt_q < CW'(ADDR_BYTES));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q      <= '0;
      complete_o <= 1'b0;
    end else begin
      complete_o <= take && (cnt_q == CW'(ADDR_BYTES - 1));
      if (take) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        addr_o[g*8 +: 8] <= '0;
      else if (take && cnt_q == CW'(g))
        addr_o[g*8 +: 8] <= byte_data;
    end
  end

endmodule

// File: rtl/rxf_hash_serial.sv
module rxf_hash_serial #(
  parameter int          ADDR_BITS = 48,
  parameter int          CRC_W     = 32,
  parameter logic [31:0] CRC_POLY  = 32'h04C11DB6,
  parameter int          HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 abort,
  input  logic                 load,
  input  logic [ADDR_BITS-1:0] addr_i,
  output logic [HASH_BITS-1:0] idx_o,
  output logic                 fin_o
);
  localparam int BCW = $clog2(ADDR_BITS);
  localparam logic [BCW-1:0] LAST = BCW'(ADDR_BITS - 1);

  logic [CRC_W-1:0]     crc_q, crc_nxt, crc_shl;
  logic [ADDR_BITS-1:0] sh_q;
  logic [BCW-1:0]       bit_q;
  logic                 busy_q;
  logic                 fb;

  always_comb begin
    fb      = crc_q[CRC_W-1] ^ sh_q[0];
    crc_shl = crc_q << 1;
    crc_nxt = fb ? ((crc_shl ^ CRC_POLY[CRC_W-1:0]) | CRC_W'(1)) : crc_shl;
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      crc_q  <= '1;
      sh_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load) begin
        crc_q  <= '1;
        sh_q   <= addr_i;
        bit_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        crc_q <= crc_nxt;
        sh_q  <= sh_q >> 1;
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST) begin
          busy_q <= 1'b0;
          fin_o  <= 1'b1;
        end
      end
    end
  end

  assign idx_o = crc_q[CRC_W-1 -: HASH_BITS];

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       abort,
  input  logic                       fin,
  input  logic [8*ADDR_BYTES-1:0]    addr_i,
  input  logic [8*ADDR_BYTES-1:0]    station_i,
  input  logic [7:0]                 cfg_i,
  input  logic [(1<<HASH_BITS)-1:0]  mask_i,
  input  logic [HASH_BITS-1:0]       idx_i,
  output logic                       done_o,
  output logic                       accept_o,
  output logic                       group_o,
  output logic [7:0]                 status_o
);
  dst_kind_e kind;
  logic      accept_c;

  always_comb begin
    if (&addr_i)        kind = DST_BCAST;
    else if (addr_i[0]) kind = DST_MULTI;
    else                kind = DST_UNICAST;

    unique case (kind)
      DST_BCAST: accept_c = cfg_i[CFG_BCAST_BIT];
      DST_MULTI: accept_c = cfg_i[CFG_MCAST_BIT] && mask_i[idx_i];
      default:   accept_c = (addr_i == station_i);
    endcase
    if (cfg_i[CFG_PROMISC_BIT]) accept_c = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
      group_o  <= 1'b0;
      status_o <= '0;
    end else begin
      done_o <= fin && !abort;
      if (fin && !abort) begin
        accept_o <= accept_c;
        group_o  <= (kind != DST_UNICAST);
        status_o <= STAT_RX_OK | ((kind != DST_UNICAST) ? STAT_GROUP : 8'h00);
      end
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          HASH_BITS  = 6,
  parameter logic [31:0] CRC_POLY   = 32'h04C11DB6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  input  logic [7:0]                rx_cfg,
  input  logic [8*ADDR_BYTES-1:0]   station_addr,
  input  logic [(1<<HASH_BITS)-1:0] mcast_mask,
  output logic                      done,
  output logic                      accept,
  output logic                      group_flag,
  output logic [7:0]                rx_status
);
  localparam int ADDR_BITS = 8 * ADDR_BYTES;

  logic [ADDR_BITS-1:0] cap_addr;
  logic                 cap_full;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 hash_fin;

  rxf_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) i_cap (
    .clk(clk), .rst(rst), .start(start),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .addr_o(cap_addr), .complete_o(cap_full)
  );

  rxf_hash_serial #(
    .ADDR_BITS(ADDR_BITS), .CRC_W(32), .CRC_POLY(CRC_POLY), .HASH_BITS(HASH_BITS)
  ) i_hash (
    .clk(clk), .rst(rst), .abort(start), .load(cap_full),
    .addr_i(cap_addr), .idx_o(hash_idx), .fin_o(hash_fin)
  );

  rxf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) i_dec (
    .clk(clk), .rst(rst), .abort(start), .fin(hash_fin),
    .addr_i(cap_addr), .station_i(station_addr), .cfg_i(rx_cfg),
    .mask_i(mcast_mask), .idx_i(hash_idx),
    .done_o(done), .accept_o(accept), .group_o(group_flag), .status_o(rx_status)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int ADDR_BITS = 48
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic [7:0]           rx_cfg,
  input logic [ADDR_BITS-1:0] station_addr,
  input logic [ADDR_BITS-1:0] cap_addr,
  input logic                 done,
  input logic                 accept,
  input logic                 group_flag,
  input logic [7:0]           rx_status
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_START_KILLS: assert property (@(posedge clk) disable iff (rst)
    start |=> !done); // R9

  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (done && $past(rx_cfg[4])) |-> accept); // R1

  AST_BCAST_GATE: assert property (@(posedge clk) disable iff (rst)
    (done && accept && !$past(rx_cfg[4]) && (&$past(cap_addr))) |-> $past(rx_cfg[2])); // R2

  AST_UNICAST_MATCH: assert property (@(posedge clk) disable iff (rst)
    (done && accept && !group_flag && !$past(rx_cfg[4]))
      |-> ($past(cap_addr) == $past(station_addr))); // R5

  AST_GROUP_STATUS: assert property (@(posedge clk) disable iff (rst)
    done |-> (group_flag == cap_addr[0] && rx_status[0] && rx_status[5] == group_flag)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!done && !accept && rx_status == 8'h00)); // R10

endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ADDR_BITS(ADDR_BITS)) i_chk (
  .clk(clk), .rst(rst), .start(start), .rx_cfg(rx_cfg),
  .station_addr(station_addr), .cap_addr(cap_addr),
  .done(done), .accept(accept), .group_flag(group_flag), .rx_status(rx_status)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [7:0]  rx_cfg = '0;
  logic [47:0] station_addr = '0;
  logic [63:0] mcast_mask = '0;
  logic        done, accept, group_flag;
  logic [7:0]  rx_status;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int         r_lat;
  logic       r_acc, r_grp;
  logic [7:0] r_stat;

  always #10 clk = ~clk;  // 50 MHz

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst(rst), .start(start), .byte_valid(byte_valid),
    .byte_data(byte_data), .rx_cfg(rx_cfg), .station_addr(station_addr),
    .mcast_mask(mcast_mask), .done(done), .accept(accept),
    .group_flag(group_flag), .rx_status(rx_status)
  );

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic f = c[31] ^ a[i];
      c = c << 1;
      if (f) c = (c ^ 32'h04C1_1DB6) | 32'h1;
    end
    return c[31:26];
  endfunction

  function automatic logic exp_acc(input logic [7:0] cfg, input logic [47:0] a,
                                   input logic [47:0] st, input logic [63:0] m);
    if (cfg[4]) return 1'b1;
    if (&a) return cfg[2];
    if (a[0]) return cfg[3] & m[hidx(a)];
    return a == st;
  endfunction

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start pulse, six bytes with 'gap' idle cycles between, 'extra' trailing bytes
  task automatic send(input logic [47:0] a, input int gap, input int extra);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int b = 0; b < 6; b++) begin
      byte_valid = 1'b1; byte_data = a[b*8 +: 8];
      if (b < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); byte_valid = 1'b0;
        end
        @(negedge clk);
      end
    end
    r_lat = -1;
    for (int j = 1; j < 200; j++) begin
      @(negedge clk);
      if (j <= extra) begin byte_valid = 1'b1; byte_data = ~a[7:0]; end
      else byte_valid = 1'b0;
      if (done) begin
        r_lat = j - 1; r_acc = accept; r_grp = group_flag; r_stat = rx_status;
        break;
      end
    end
    byte_valid = 1'b0;
    @(negedge clk);
    chk(!done, "R7 done single cycle", done, 0);
  endtask

  task automatic frame(input logic [47:0] a, input string req);
    logic e = exp_acc(rx_cfg, a, station_addr, mcast_mask);
    send(a, 0, 0);
    chk(r_lat == 50, "R7 latency", r_lat, 50);
    chk(r_acc == e, req, r_acc, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R7 actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [47:0] st, ma, uc, bc;
    st = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    ma = mk(8'h01, 8'h00, 8'h5e, 8'h12, 8'h34, 8'h56);
    uc = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h54);
    bc = '1;
    station_addr = st;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!done && !accept && !group_flag && rx_status == 0, "R10 reset state",
        {done, accept, group_flag, rx_status}, 0);

    // R1 R2 R3 R5: sweep all low configuration values over four kinds
    mcast_mask = 64'hA5A5_0F0F_3C3C_9999;
    for (int c = 0; c < 32; c++) begin
      rx_cfg = 8'(c);
      frame(st, "R5 R1 matching unicast");
      frame(uc, "R5 R1 foreign unicast");
      frame(bc, "R2 R1 broadcast");
      chk(r_stat == 8'h21 && r_grp, "R6 broadcast status", r_stat, 8'h21);
      frame(ma, "R3 R1 multicast");
    end

    // R2: broadcast not admitted through the hash path
    rx_cfg = 8'h08; mcast_mask = '1;
    send(bc, 0, 0);
    chk(r_acc == 0, "R2 broadcast with only multicast enabled", r_acc, 0);

    // R4 R3: per-address single-bit masks
    rx_cfg = 8'h08;
    for (int i = 0; i < 64; i++) begin
      logic [47:0] a = mk(8'h01, 8'h00, 8'h5e, 8'h00, 8'(i), 8'h07);
      logic [5:0]  h = hidx(a);
      mcast_mask = 64'h1 << h;
      send(a, 0, 0);
      chk(r_acc == 1, "R4 hash bit hit", r_acc, 1);
      chk(r_grp && r_stat == 8'h21, "R6 multicast status", r_stat, 8'h21);
      mcast_mask = ~(64'h1 << h);
      send(a, 0, 0);
      chk(r_acc == 0, "R4 hash bit miss", r_acc, 0);
    end

    // R5: mismatch in each byte position, all group enables on
    rx_cfg = 8'h0C; mcast_mask = '1;
    for (int b = 0; b < 6; b++) begin
      logic [47:0] a = st;
      a[b*8 + 1] = ~a[b*8 + 1];
      send(a, 0, 0);
      chk(r_acc == 0, "R5 one-byte mismatch", r_acc, 0);
    end
    send(st, 0, 0);
    chk(r_acc == 1 && r_stat == 8'h01 && !r_grp, "R5 R6 unicast match status", r_stat, 8'h01);

    // R7: gaps between bytes do not change latency
    send(st, 3, 0);
    chk(r_lat == 50, "R7 latency with gaps", r_lat, 50);
    chk(r_acc == 1, "R7 gapped frame verdict", r_acc, 1);

    // R8: trailing bytes ignored
    send(st, 0, 4);
    chk(r_acc == 1 && r_lat == 50, "R8 extra bytes ignored", r_acc, 1);

    // R9: start mid-evaluation abandons the frame
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int b = 0; b < 6; b++) begin
      byte_valid = 1'b1; byte_data = st[b*8 +: 8];
      @(negedge clk);
    end
    byte_valid = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      chk(seen == 0, "R9 abort suppresses done", seen, 0);
    end
    send(uc, 0, 0);
    chk(r_lat == 50 && r_acc == 0, "R9 frame after abort", r_acc, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule